// File: doc/BRIEF.md
# Short/Long Bus Reset Sequencer

This block produces the bus reset pulse for a serial-bus physical layer that can send both a brief reset and the conventional long reset. A one-cycle request strobe starts one of two sequences. A long request drives a long pulse. A short request drives a short pulse, and how it does so depends on the bus state. If the bus is already initialized, the block first competes for the bus as a fair-arbitration requester and sends the short pulse in place of a packet once it is granted. If the bus has not been initialized, it sends the short pulse at once.

A short pulse can fail. After every short pulse the block watches a failure input for a fixed number of cycles. A failure seen in that window makes the block send a long pulse, so a node that only understands long resets still gets reset. A static strap turns short resets off, and with the strap off every request produces a long pulse.

Pulse widths come from a clock-frequency parameter and are rounded up to whole cycles. The arbitration engine, the line signalling and the detection of resets from other nodes sit outside this block.

Top module: `bus_reset_seq`

## Requirements
- R1: After reset, `fair_req_o`, `rst_drive_o`, `short_pulse_o`, `busy_o` and `done_o` are all 0.
- R2: A `long_req_i` strobe accepted while idle sets `rst_drive_o` high, with `short_pulse_o` low, from the next cycle. The pulse lasts ceil(CLK_HZ·166 µs) cycles, which is 20750 at 125 MHz.
- R3: When `short_en_i` is 0, a `short_req_i` strobe produces the same long pulse as R2 and never raises `fair_req_o`.
- R4: When `short_en_i` is 1 and `bus_init_i` is 1, a `short_req_i` strobe raises `fair_req_o` from the next cycle and keeps `rst_drive_o` low until `fair_grant_i` is sampled high. The cycle after the grant, `fair_req_o` falls and a short pulse begins (`rst_drive_o` and `short_pulse_o` both high). The short pulse lasts ceil(CLK_HZ·1.4 µs) cycles, which is 175 at 125 MHz.
- R5: When `short_en_i` is 1 and `bus_init_i` is 0, a `short_req_i` strobe starts the short pulse of R4 in the next cycle, without arbitration.
- R6: The failure window covers the FAIL_WIN cycles (16 by default) that follow a short pulse. If `rst_fail_i` is sampled high in any of those cycles, including the last one, a long pulse as in R2 starts in the next cycle.
- R7: `rst_fail_i` has no effect while a short pulse is being driven, and no effect once the failure window has ended.
- R8: `busy_o` is high from the cycle after a request is accepted until the last pulse cycle. `done_o` is high for exactly one cycle, the cycle after the last pulse cycle, and `busy_o` is low in that cycle.
- R9: Request strobes that arrive while `busy_o` is high are dropped. No new sequence follows the current one.
- R10: If `long_req_i` and `short_req_i` are high in the same idle cycle, the long request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| short_en_i | input | 1 | Static strap: 1 enables short resets |
| long_req_i | input | 1 | One-cycle strobe requesting a long reset |
| short_req_i | input | 1 | One-cycle strobe requesting an arbitrated short reset |
| bus_init_i | input | 1 | The bus has been initialized |
| fair_grant_i | input | 1 | Grant from the fair arbitration engine |
| rst_fail_i | input | 1 | The short reset did not take effect |
| fair_req_o | output | 1 | Fair-arbitration request |
| rst_drive_o | output | 1 | Drive reset onto the bus |
| short_pulse_o | output | 1 | The current pulse is the short one |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle strobe when a sequence completes |

## Verification
The assertions assume that `short_en_i` and `bus_init_i` stay constant while a sequence runs. They also assume that `fair_grant_i` arrives only while `fair_req_o` is high and that request strobes last one cycle. The stimulus changes the strap and the bus-initialized flag only between sequences, when the block is idle. It raises the grant for a single cycle during arbitration, and it drives every input on the falling clock edge.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_SHORT,
    ST_WIN,
    ST_LONG
  } brs_state_e;

  // cycles covering ns nanoseconds at f_hz, rounded up
  function automatic int unsigned ns_to_cyc(longint unsigned f_hz, longint unsigned ns);
    return int'((f_hz * ns + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction
endpackage

// File: rtl/brs_timer.sv
module brs_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import brs_pkg::*;
#(
  parameter int unsigned CW        = 16,
  parameter int unsigned SHORT_CYC = 175,
  parameter int unsigned LONG_CYC  = 20750,
  parameter int unsigned FAIL_WIN  = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          short_en_i,
  input  logic          long_req_i,
  input  logic          short_req_i,
  input  logic          bus_init_i,
  input  logic          fair_grant_i,
  input  logic          rst_fail_i,
  input  logic          zero_i,
  output logic          load_o,
  output logic [CW-1:0] val_o,
  output logic          fair_req_o,
  output logic          rst_drive_o,
  output logic          short_pulse_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] WIN_LD   = CW'(FAIL_WIN - 1);

  brs_state_e st_q, st_d;
  logic       fin, done_q;

  always_comb begin
    st_d   = st_q;
    load_o = 1'b0;
    val_o  = '0;
    fin    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (long_req_i || (short_req_i && !short_en_i)) begin
          st_d = ST_LONG; load_o = 1'b1; val_o = LONG_LD;
        end else if (short_req_i) begin
          if (bus_init_i) st_d = ST_ARB;
          else begin st_d = ST_SHORT; load_o = 1'b1; val_o = SHORT_LD; end
        end
      end
      ST_ARB: if (fair_grant_i) begin
        st_d = ST_SHORT; load_o = 1'b1; val_o = SHORT_LD;
      end
      ST_SHORT: if (zero_i) begin
        st_d = ST_WIN; load_o = 1'b1; val_o = WIN_LD;
      end
      ST_WIN: begin
        if (rst_fail_i) begin
          st_d = ST_LONG; load_o = 1'b1; val_o = LONG_LD;
        end else if (zero_i) begin
          st_d = ST_IDLE; fin = 1'b1;
        end
      end
      ST_LONG: if (zero_i) begin
        st_d = ST_IDLE; fin = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
    end
  end

  assign fair_req_o    = (st_q == ST_ARB);
  assign short_pulse_o = (st_q == ST_SHORT);
  assign rst_drive_o   = (st_q == ST_SHORT) || (st_q == ST_LONG);
  assign busy_o        = (st_q != ST_IDLE);
  assign done_o        = done_q;

  AST_LONG_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && long_req_i) |=> (rst_drive_o && !short_pulse_o)); // R2
  AST_STRAP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && short_req_i && !short_en_i) |=> (rst_drive_o && !fair_req_o)); // R3
  AST_GRANT_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fair_req_o && fair_grant_i) |=> (short_pulse_o && !fair_req_o)); // R4
  AST_ARB_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fair_req_o && !fair_grant_i) |=> (fair_req_o && !rst_drive_o)); // R4
  AST_IMM_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && short_req_i && !long_req_i && short_en_i && !bus_init_i) |=> short_pulse_o); // R5
  AST_FAIL_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WIN && rst_fail_i) |=> (rst_drive_o && !short_pulse_o)); // R6
  AST_DONE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(rst_drive_o || st_q == ST_WIN))); // R8
  AST_BOTH_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && long_req_i && short_req_i) |=> !short_pulse_o); // R10
endmodule

// File: rtl/bus_reset_seq.sv
module bus_reset_seq
  import brs_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 125_000_000,
  parameter int unsigned SHORT_NS = 1_400,
  parameter int unsigned LONG_NS  = 166_000,
  parameter int unsigned FAIL_WIN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic short_en_i,
  input  logic long_req_i,
  input  logic short_req_i,
  input  logic bus_init_i,
  input  logic fair_grant_i,
  input  logic rst_fail_i,
  output logic fair_req_o,
  output logic rst_drive_o,
  output logic short_pulse_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned SHORT_CYC = ns_to_cyc(longint'(CLK_HZ), longint'(SHORT_NS));
  localparam int unsigned LONG_CYC  = ns_to_cyc(longint'(CLK_HZ), longint'(LONG_NS));
  localparam int unsigned MAX_CYC   = (LONG_CYC > FAIL_WIN) ? LONG_CYC : FAIL_WIN;
  localparam int unsigned CW        = $clog2(MAX_CYC + 1);

  logic          t_load, t_zero;
  logic [CW-1:0] t_val;

  brs_timer #(.CW(CW)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (t_load),
    .val_i  (t_val),
    .zero_o (t_zero)
  );

  brs_ctrl #(
    .CW        (CW),
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC),
    .FAIL_WIN  (FAIL_WIN)
  ) i_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .short_en_i    (short_en_i),
    .long_req_i    (long_req_i),
    .short_req_i   (short_req_i),
    .bus_init_i    (bus_init_i),
    .fair_grant_i  (fair_grant_i),
    .rst_fail_i    (rst_fail_i),
    .zero_i        (t_zero),
    .load_o        (t_load),
    .val_o         (t_val),
    .fair_req_o    (fair_req_o),
    .rst_drive_o   (rst_drive_o),
    .short_pulse_o (short_pulse_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );
endmodule

// File: tb/test_bus_reset_seq.sv
module test_bus_reset_seq;
  localparam int SHORT_EXP = 175;    // ceil(125e6 * 1.4e-6)
  localparam int LONG_EXP  = 20750;  // ceil(125e6 * 166e-6)
  localparam int WIN       = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic short_en = 1'b1, long_req = 1'b0, short_req = 1'b0;
  logic bus_init = 1'b0, grant = 1'b0, fail = 1'b0;
  logic fair_req, drive, short_p, busy, done;
  int   n_chk = 0, n_err = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  bus_reset_seq i_bus_reset_seq (
    .clk_i(clk), .rst_ni(rst_n), .short_en_i(short_en), .long_req_i(long_req),
    .short_req_i(short_req), .bus_init_i(bus_init), .fair_grant_i(grant),
    .rst_fail_i(fail), .fair_req_o(fair_req), .rst_drive_o(drive),
    .short_pulse_o(short_p), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fire(input bit lng, input bit sht);
    @(negedge clk); long_req = lng; short_req = sht;
    @(negedge clk); long_req = 1'b0; short_req = 1'b0;
  endtask

  // counts consecutive drive cycles from the current negedge, checks width and kind
  task automatic meas(input int exp_len, input bit exp_short, input string tag);
    int len = 0;
    bit kind_ok = 1'b1;
    while (drive && len <= LONG_EXP + 1) begin
      if (short_p != exp_short) kind_ok = 1'b0;
      len++;
      @(negedge clk);
    end
    chk(len == exp_len, {tag, " width"}, len, exp_len);
    chk(kind_ok, {tag, " kind"}, int'(!kind_ok), 0);
  endtask

  task automatic check_done(input string tag);
    chk(done && !busy, {tag, " done strobe"}, {30'd0, done, busy}, 2);
    @(negedge clk);
    chk(!done, {tag, " done one cycle"}, int'(done), 0);
  endtask

  task automatic t_reset();
    chk({fair_req, drive, short_p, busy, done} == 5'b0, "R1 reset outputs",
        int'({fair_req, drive, short_p, busy, done}), 0);
  endtask

  task automatic t_long();
    short_en = 1'b1; bus_init = 1'b1;
    fire(1'b1, 1'b0);
    chk(drive && busy, "R2 long starts next cycle / R8 busy", int'(drive), 1);
    meas(LONG_EXP, 1'b0, "R2 long");
    check_done("R8 long");
  endtask

  task automatic t_strap_off();
    short_en = 1'b0; bus_init = 1'b1;
    fire(1'b0, 1'b1);
    chk(drive && !fair_req, "R3 strap off gives long", int'(fair_req), 0);
    meas(LONG_EXP, 1'b0, "R3 long");
    check_done("R3");
    short_en = 1'b1;
  endtask

  task automatic t_arb();
    bit ok = 1'b1;
    short_en = 1'b1; bus_init = 1'b1;
    fire(1'b0, 1'b1);
    for (int i = 0; i < 6; i++) begin
      if (!fair_req || drive || !busy) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R4 arbitration holds without drive", int'(ok), 1);
    grant = 1'b1;
    @(negedge clk); grant = 1'b0;
    chk(drive && short_p && !fair_req, "R4 short after grant",
        int'({drive, short_p, fair_req}), 6);
    fail = 1'b1;  // R7: during the pulse, must be ignored
    repeat (10) @(negedge clk);
    fail = 1'b0;
    meas(SHORT_EXP - 10, 1'b1, "R4 short");
    chk(busy, "R8 busy during window", int'(busy), 1);
    ok = 1'b1;
    for (int i = 0; i < WIN; i++) begin
      if (drive) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R7 fail during pulse ignored", int'(ok), 1);
    check_done("R7 arb");
  endtask

  task automatic t_imm_fail_last();
    short_en = 1'b1; bus_init = 1'b0;
    fire(1'b0, 1'b1);
    chk(drive && short_p && !fair_req, "R5 immediate short",
        int'({drive, short_p, fair_req}), 6);
    meas(SHORT_EXP, 1'b1, "R5 short");
    repeat (WIN - 1) @(negedge clk);
    fail = 1'b1;  // last window cycle
    @(negedge clk); fail = 1'b0;
    chk(drive && !short_p, "R6 fallback long in last window cycle",
        int'({drive, short_p}), 2);
    meas(LONG_EXP, 1'b0, "R6 long");
    check_done("R6");
  endtask

  task automatic t_fail_late();
    bit ok = 1'b1;
    short_en = 1'b1; bus_init = 1'b0;
    fire(1'b0, 1'b1);
    meas(SHORT_EXP, 1'b1, "R7 short");
    repeat (WIN) @(negedge clk);
    chk(done, "R7 window ended", int'(done), 1);
    fail = 1'b1;
    @(negedge clk); fail = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (drive || busy) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R7 late fail ignored", int'(ok), 1);
  endtask

  task automatic t_busy_ignore();
    bit ok = 1'b1;
    short_en = 1'b1; bus_init = 1'b0;
    fire(1'b1, 1'b0);
    repeat (100) @(negedge clk);
    short_req = 1'b1;
    @(negedge clk); short_req = 1'b0;
    meas(LONG_EXP - 101, 1'b0, "R9 long");
    check_done("R9");
    for (int i = 0; i < 20; i++) begin
      if (busy || drive || fair_req) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R9 request while busy dropped", int'(ok), 1);
  endtask

  task automatic t_both();
    short_en = 1'b1; bus_init = 1'b1;
    fire(1'b1, 1'b1);
    chk(drive && !short_p && !fair_req, "R10 long wins",
        int'({drive, short_p, fair_req}), 4);
    meas(LONG_EXP, 1'b0, "R10 long");
    check_done("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_long();
    t_strap_off();
    t_arb();
    t_imm_fail_last();
    t_fail_late();
    t_busy_ignore();
    t_both();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200_000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule